// File: doc/BRIEF.md
# Packet FIFO with Automatic Error Recovery

This block is the byte buffer of one endpoint. It sits between a USB serial engine and the local side, which is a microcontroller or a DMA channel. The `tx_dir` input sets the direction of flow.

In receive direction the serial engine writes bytes. The local side can see a packet only after the packet closes with a clean end marker. In transmit direction the local side loads bytes and the serial engine reads them out. The space a packet uses is released only when its handshake outcome is known.

The buffer keeps two pointer pairs. The working pointers move with every byte. The committed pointers mark where the current packet began. When automatic handling is enabled, the block recovers from errors by moving one pointer back onto its committed partner:

- In transmit, a missing handshake rewinds the read pointer, so the same packet is sent again.
- In receive, an errored packet is cut off by moving the write pointer back.

An isochronous mode input selects the behaviour for streaming traffic. In that mode a transmitted packet is never replayed, and an errored received packet is discarded outright.

Top module: `pkt_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `dma_valid`=0 and `err_flag`=0.
- R2: In receive direction (`tx_dir`=0), pushed bytes stay invisible (`dma_valid`=0) until a `pkt_end` pulse with `pkt_err`=0. Once committed, the bytes are popped in push order. A push in the same cycle as `pkt_end` belongs to the packet.
- R3: In receive direction with `auto_en`=1 and `iso_mode`=0, a `pkt_end` with `pkt_err`=1 removes the whole packet. Earlier committed data stays readable, `err_flag` is not set, and the next packet is stored from the cleared position.
- R4: In receive direction with `auto_en`=1 and `iso_mode`=1, an errored packet is discarded. None of its bytes ever raise `dma_valid`, and the buffer returns to empty if it held nothing else.
- R5: In receive direction with `auto_en`=0, an errored packet is committed like a good one and `err_flag` is set. `err_flag` stays set until an `err_clr` pulse, and a new set in the same cycle as `err_clr` wins.
- R6: In transmit direction (`tx_dir`=1), pushed bytes are readable in the cycle after the push. The space of sent bytes stays occupied (`empty`=0) until `hs_ack` releases it.
- R7: In transmit direction with `auto_en`=1 and `iso_mode`=0, `hs_none` rewinds reading to the start of the unacknowledged packet, and the same bytes are read again in the same order.
- R8: In transmit direction with `iso_mode`=1 or `auto_en`=0, `hs_none` releases the sent bytes with no replay. `err_flag` is set only when `auto_en`=0 and `iso_mode`=0.
- R9: `full` is 1 when `DEPTH` bytes are held, counting bytes that are uncommitted or unacknowledged. A push while `full` is ignored, and a pop while `dma_valid`=0 is ignored.
- R10: In transmit direction, a `pop` in the same cycle as `hs_ack` or `hs_none` is ignored.
- R11: In a cycle with no push, pop, end marker, handshake or `err_clr`, the outputs `dma_valid`, `full`, `empty` and `err_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_dir | input | 1 | 1 = transmit (local loads, engine reads), 0 = receive |
| auto_en | input | 1 | Enables automatic replay/flush/discard |
| iso_mode | input | 1 | 1 = isochronous behaviour, 0 = bulk/interrupt/control |
| push | input | 1 | Write one byte |
| push_data | input | DW | Byte to write |
| pkt_end | input | 1 | Receive end-of-packet marker |
| pkt_err | input | 1 | Receive packet had CRC or bit-stuff error (valid with `pkt_end`) |
| hs_ack | input | 1 | Transmit packet acknowledged |
| hs_none | input | 1 | Transmit packet got no handshake |
| pop | input | 1 | Read one byte |
| err_clr | input | 1 | Clears `err_flag` |
| pop_data | output | DW | Byte at the read pointer |
| dma_valid | output | 1 | Readable committed data present |
| full | output | 1 | `DEPTH` bytes held |
| empty | output | 1 | No bytes held |
| err_flag | output | 1 | Sticky error status for software |

## Verification
The checker watches several relations on every cycle:

- `full` and `empty` are never high together.
- A flushed receive packet never lights `dma_valid`.
- A replay always leaves data readable.
- An acknowledge after the last byte empties the buffer.
- Unhandled errors set `err_flag`.
- Idle cycles leave the status outputs untouched.

Byte ordering is something only the bench scenarios can show: that a replayed packet carries the same bytes, that a dropped packet leaves no trace in the data that follows, and that a pop colliding with a handshake is dropped.

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_dir,
  input  logic          auto_en,
  input  logic          iso_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pkt_end,
  input  logic          pkt_err,
  input  logic          hs_ack,
  input  logic          hs_none,
  input  logic          pop,
  input  logic          err_clr,
  output logic [DW-1:0] pop_data,
  output logic          dma_valid,
  output logic          full,
  output logic          empty,
  output logic          err_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, wr_cmt, rd_ptr, rd_cmt;

  wire [AW:0] stored   = wr_ptr - rd_cmt;
  wire [AW:0] readable = wr_cmt - rd_ptr;

  assign full      = (stored == CAP);
  assign empty     = (stored == '0);
  assign dma_valid = (readable != '0);
  assign pop_data  = mem[rd_ptr[AW-1:0]];

  wire push_ok    = push && !full;
  wire hs_any     = tx_dir && (hs_ack || hs_none);
  wire pop_ok     = pop && dma_valid && !hs_any;
  wire rx_end     = !tx_dir && pkt_end;
  wire rx_drop    = rx_end && pkt_err && auto_en;
  wire tx_reload  = tx_dir && hs_none && auto_en && !iso_mode;
  wire tx_release = tx_dir && (hs_ack || (hs_none && !tx_reload));
  wire err_set    = (rx_end && pkt_err && !auto_en) ||
                    (tx_dir && hs_none && !auto_en && !iso_mode);

  wire [AW:0] wr_nxt = wr_ptr + {{AW{1'b0}}, push_ok};
  wire [AW:0] rd_nxt = rd_ptr + {{AW{1'b0}}, pop_ok};

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      wr_cmt   <= '0;
      rd_ptr   <= '0;
      rd_cmt   <= '0;
      err_flag <= 1'b0;
    end else begin
      wr_ptr <= rx_drop ? wr_cmt : wr_nxt;
      if (tx_dir || (rx_end && !rx_drop)) wr_cmt <= wr_nxt;
      rd_ptr <= tx_reload ? rd_cmt : rd_nxt;
      if (!tx_dir)         rd_cmt <= rd_nxt;
      else if (tx_release) rd_cmt <= rd_ptr;
      if (err_set)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_dir,
  input logic auto_en,
  input logic iso_mode,
  input logic push,
  input logic pkt_end,
  input logic pkt_err,
  input logic hs_ack,
  input logic hs_none,
  input logic pop,
  input logic err_clr,
  input logic dma_valid,
  input logic full,
  input logic empty,
  input logic err_flag
);
  a_r9_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r3_flush_hides: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_dir && auto_en && pkt_end && pkt_err && !dma_valid) |=> !dma_valid);

  a_r7_reload_readable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dir && auto_en && !iso_mode && hs_none && !empty) |=> dma_valid);

  a_r6_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dir && hs_ack && !dma_valid && !push) |=> empty);

  a_r5_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_dir && !auto_en && pkt_end && pkt_err) |=> err_flag);

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !pkt_end && !hs_ack && !hs_none && !err_clr)
    |=> ($stable(dma_valid) && $stable(full) && $stable(empty) && $stable(err_flag)));
endmodule

bind pkt_fifo pkt_fifo_chk u_chk (.*);

// File: tb/tb_pkt_fifo.sv
module tb_pkt_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_dir = 1'b0, auto_en = 1'b1, iso_mode = 1'b0;
  logic push = 1'b0, pkt_end = 1'b0, pkt_err = 1'b0;
  logic hs_ack = 1'b0, hs_none = 1'b0, err_clr = 1'b0;
  logic [7:0] push_data = '0;
  logic mon_pop = 1'b0, drv_pop = 1'b0, mon_en = 1'b0;
  logic pop;
  logic [7:0] pop_data;
  logic dma_valid, full, empty, err_flag;

  assign pop = mon_pop | drv_pop;
  always #4 clk = ~clk;

  pkt_fifo dut (.*);

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R2";
  byte unsigned exp_q[$];

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && dma_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: actual %0d expected none", cur_req, pop_data);
      end else begin
        byte unsigned e;
        e = exp_q.pop_front();
        if (pop_data !== e) begin
          n_bad++;
          $display("FAIL %s: actual %0d expected %0d", cur_req, pop_data, e);
        end
      end
      mon_pop <= 1'b1;
    end else mon_pop <= 1'b0;
  end

  task automatic push_byte(byte unsigned b);
    push = 1'b1; push_data = b; step(); push = 1'b0;
  endtask

  task automatic send_pkt(int n, byte unsigned base, bit q);
    for (int i = 0; i < n; i++) begin
      push_byte(byte'(base + i));
      if (q) exp_q.push_back(byte'(base + i));
    end
  endtask

  task automatic end_pkt(bit err);
    pkt_end = 1'b1; pkt_err = err; step(); pkt_end = 1'b0; pkt_err = 1'b0;
  endtask

  task automatic pulse_ack(); hs_ack = 1'b1; step(); hs_ack = 1'b0; endtask
  task automatic pulse_none(); hs_none = 1'b1; step(); hs_none = 1'b0; endtask
  task automatic pulse_clr(); err_clr = 1'b1; step(); err_clr = 1'b0; endtask

  task automatic drain(string req);
    cur_req = req;
    mon_en = 1'b1;
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) step();
    repeat (3) step();
    mon_en = 1'b0;
    step(); step();
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  bit done = 1'b0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    // R1 reset state
    check(empty == 1, "R1", empty, 1);
    check(full == 0, "R1", full, 0);
    check(dma_valid == 0, "R1", dma_valid, 0);
    check(err_flag == 0, "R1", err_flag, 0);

    // R2 receive commit on good end
    tx_dir = 0; auto_en = 1; iso_mode = 0;
    send_pkt(4, 8'h10, 1);
    check(dma_valid == 0, "R2", dma_valid, 0);
    repeat (5) step();
    check(dma_valid == 0 && empty == 0, "R11", dma_valid, 0);
    end_pkt(0);
    check(dma_valid == 1, "R2", dma_valid, 1);
    drain("R2");
    check(empty == 1, "R2", empty, 1);

    // R3 non-iso receive flush
    send_pkt(3, 8'h20, 1); end_pkt(0);
    send_pkt(2, 8'hE0, 0); end_pkt(1);
    check(err_flag == 0, "R3", err_flag, 0);
    send_pkt(2, 8'h30, 1); end_pkt(0);
    drain("R3");
    check(empty == 1, "R3", empty, 1);

    // R4 iso receive discard
    iso_mode = 1;
    send_pkt(5, 8'h40, 0); end_pkt(1);
    check(dma_valid == 0, "R4", dma_valid, 0);
    check(empty == 1, "R4", empty, 1);
    send_pkt(2, 8'h50, 1); end_pkt(0);
    drain("R4");

    // R5 auto off: errored packet kept, flag raised
    iso_mode = 0; auto_en = 0;
    send_pkt(2, 8'h55, 1); end_pkt(1);
    check(err_flag == 1, "R5", err_flag, 1);
    drain("R5");
    pulse_clr();
    check(err_flag == 0, "R5", err_flag, 0);

    // R6 transmit and acknowledge
    tx_dir = 1; auto_en = 1;
    push_byte(8'h60);
    check(dma_valid == 1, "R6", dma_valid, 1);
    exp_q.push_back(8'h60);
    send_pkt(2, 8'h61, 1);
    drain("R6");
    check(empty == 0, "R6", empty, 0);
    pulse_ack();
    check(empty == 1, "R6", empty, 1);

    // R7 replay on missing handshake
    send_pkt(3, 8'h70, 1);
    drain("R7");
    pulse_none();
    check(dma_valid == 1, "R7", dma_valid, 1);
    for (int i = 0; i < 3; i++) exp_q.push_back(byte'(8'h70 + i));
    drain("R7");
    pulse_ack();
    check(empty == 1, "R7", empty, 1);

    // R8 iso / auto off: no replay
    iso_mode = 1;
    send_pkt(2, 8'h80, 1); drain("R8");
    pulse_none();
    check(empty == 1 && dma_valid == 0, "R8", empty, 1);
    check(err_flag == 0, "R8", err_flag, 0);
    iso_mode = 0; auto_en = 0;
    send_pkt(2, 8'h88, 1); drain("R8");
    pulse_none();
    check(empty == 1, "R8", empty, 1);
    check(err_flag == 1, "R8", err_flag, 1);
    pulse_clr();

    // R9 full limit
    auto_en = 1;
    send_pkt(64, 8'h00, 1);
    check(full == 1, "R9", full, 1);
    push_byte(8'hFF);
    check(full == 1, "R9", full, 1);
    drain("R9");
    check(empty == 0, "R9", empty, 0);
    pulse_ack();
    check(empty == 1 && full == 0, "R9", empty, 1);

    // R10 pop colliding with handshake ignored
    send_pkt(2, 8'hA1, 1);
    drv_pop = 1; hs_ack = 1; step(); drv_pop = 0; hs_ack = 0;
    check(pop_data == 8'hA1, "R10", pop_data, 8'hA1);
    drain("R10");
    pulse_ack();
    check(empty == 1, "R10", empty, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule